// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block is the reset controller of a small microcontroller. It gathers reset requests from four origins: the power-on detector, a low-voltage comparator, the bidirectional external reset pin, and a bus-reset indication from the USB function. Power-on works as an asynchronous reset of the whole block. The other three are sampled on the system clock. After any request the block runs a fixed two-phase sequence. First it pulls the reset pin low through an open-drain control while a counter runs for `PIN_CYCLES` clocks. Then it keeps the CPU in reset for `TAIL_CYCLES` more clocks and releases it, so the CPU can fetch its reset vector.

A one-hot status word records the origin of the most recent reset. Software can read it at any time; reading has no effect on it. A separate power-class reset output is asserted only in sequences started by power-on or low voltage. It clears registers that ordinary resets must leave untouched. A new request that arrives during a sequence restarts the sequence from its first phase. The pin is read through a synchronizer. The block does not treat it as a request while the block itself is pulling it low.

Top module: `rst_sequencer`

## Requirements
- R1: While `porIn` is high, the block holds `pinPullDown`, `cpuRst` and `powerRst` at 1 and holds `status` at 4'b0001 (bit 0 = power-on).
- R2: After the last clock edge that samples a request, `pinPullDown` stays 1 for exactly `PIN_CYCLES` clock cycles. For power-on, this counts from the last edge with `porIn` high.
- R3: After `pinPullDown` falls, `cpuRst` stays 1 for exactly `TAIL_CYCLES` cycles and then falls. `pinPullDown` is never 1 while `cpuRst` is 0.
- R4: At each accepted request, `status` becomes one-hot: bit 1 = low voltage, bit 2 = external pin, bit 3 = USB bus reset. When requests coincide, low voltage wins over the pin, and the pin wins over USB.
- R5: `powerRst` is 1 only inside a sequence that power-on or low voltage started or restarted. It falls together with `cpuRst`.
- R6: A request accepted during either phase restarts the first phase. An `lviIn` held high for N cycles therefore keeps the pin low for N-1+`PIN_CYCLES` cycles.
- R7: A low level on `pinIn` is a request once it has passed a two-flop synchronizer. It is ignored while `pinPullDown` is 1 and for two cycles after it falls.
- R8: `usbReq` has no effect while `usbEn` is 0.
- R9: `status` keeps its value between reset events; reading it never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived system clock |
| porIn | input | 1 | Power-on reset, active high, asynchronous |
| lviIn | input | 1 | Low-voltage comparator output, active high |
| pinIn | input | 1 | Level seen on the external reset pin (0 = asserted) |
| usbReq | input | 1 | USB bus-reset detected, active high |
| usbEn | input | 1 | Allows `usbReq` to start a reset |
| pinPullDown | output | 1 | Open-drain control: 1 pulls the reset pin low |
| cpuRst | output | 1 | CPU reset, active high |
| powerRst | output | 1 | Reset for registers cleared only by power-class sources |
| status | output | 4 | One-hot origin of the latest reset |

## Verification
The assertions check on every cycle the ordering rules between the outputs:
- the pin is never pulled low after CPU release;
- the power-class reset never outlives the CPU reset;
- the status word stays one-hot;
- an accepted request always reloads the first phase;
- a disabled USB request leaves the status untouched.

Only the bench's scenarios can show the exact phase lengths for each source, the lengthening under a held low-voltage input, restarts from the tail phase, priority between coinciding requests, and the masking of the pin while the block drives it.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HOLD, PH_TAIL} phase_t;

  typedef struct packed {
    logic restart;
    logic toTail;
    logic finish;
  } seq_strobe_t;

  localparam int NUM_SRC = 4;
  localparam int SRC_POR = 0;
  localparam int SRC_LVI = 1;
  localparam int SRC_PIN = 2;
  localparam int SRC_USB = 3;
endpackage

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        porIn,
  input  logic        reqAny,
  input  logic        holdDone,
  input  logic        tailDone,
  output seq_strobe_t strobe
);
  phase_t phase;

  always_comb begin
    strobe.restart = reqAny;
    strobe.toTail  = !reqAny && (phase == PH_HOLD) && holdDone;
    strobe.finish  = !reqAny && (phase == PH_TAIL) && tailDone;
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)               phase <= PH_HOLD;
    else if (strobe.restart) phase <= PH_HOLD;
    else if (strobe.toTail)  phase <= PH_TAIL;
    else if (strobe.finish)  phase <= PH_IDLE;
  end

  // R6: an accepted request always returns the sequencer to the hold phase
  assert_restart_hold_R6: assert property (@(posedge clk) disable iff (porIn)
    reqAny |=> (phase == PH_HOLD));
endmodule

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int PIN_CYCLES  = 4096,
  parameter int TAIL_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic               lviIn,
  input  logic               pinIn,
  input  logic               usbReq,
  input  logic               usbEn,
  input  seq_strobe_t        strobe,
  output logic               reqAny,
  output logic               holdDone,
  output logic               tailDone,
  output logic               pinPullDown,
  output logic               cpuRst,
  output logic               powerRst,
  output logic [NUM_SRC-1:0] status
);
  localparam int MAX_CNT = (PIN_CYCLES > TAIL_CYCLES) ? PIN_CYCLES : TAIL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [SYNC_STAGES-1:0] pinSync;
  logic [SYNC_STAGES-1:0] pdHist;
  logic [CNT_W-1:0]       cnt;
  logic [NUM_SRC-1:0]     reqVec;
  logic [NUM_SRC-1:0]     newStatus;
  logic                   pinReq;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      pinSync <= '1;
      pdHist  <= '1;
    end else begin
      pinSync <= {pinSync[SYNC_STAGES-2:0], pinIn};
      pdHist  <= {pdHist[SYNC_STAGES-2:0], pinPullDown};
    end
  end

  // Pin request only when the low level cannot be our own pull-down.
  assign pinReq = !pinSync[SYNC_STAGES-1] && !pinPullDown && !(|pdHist);

  always_comb begin
    reqVec          = '0;
    reqVec[SRC_LVI] = lviIn;
    reqVec[SRC_PIN] = pinReq;
    reqVec[SRC_USB] = usbReq && usbEn;
    reqAny          = |reqVec;
    newStatus       = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (reqVec[i] && (newStatus == '0)) newStatus[i] = 1'b1;
    end
  end

  assign holdDone = (cnt == CNT_W'(PIN_CYCLES - 1));
  assign tailDone = (cnt == CNT_W'(TAIL_CYCLES - 1));

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      cnt         <= '0;
      pinPullDown <= 1'b1;
      cpuRst      <= 1'b1;
      powerRst    <= 1'b1;
      status      <= NUM_SRC'(1) << SRC_POR;
    end else if (strobe.restart) begin
      cnt         <= '0;
      pinPullDown <= 1'b1;
      cpuRst      <= 1'b1;
      powerRst    <= powerRst | lviIn;
      status      <= newStatus;
    end else if (strobe.toTail) begin
      cnt         <= '0;
      pinPullDown <= 1'b0;
    end else if (strobe.finish) begin
      cnt      <= '0;
      cpuRst   <= 1'b0;
      powerRst <= 1'b0;
    end else if (cpuRst) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_pin_within_cpu_R3: assert property (@(posedge clk) disable iff (porIn)
    pinPullDown |-> cpuRst);
  assert_hold_bound_R2: assert property (@(posedge clk) disable iff (porIn)
    pinPullDown |-> (cnt < CNT_W'(PIN_CYCLES)));
  assert_power_within_cpu_R5: assert property (@(posedge clk) disable iff (porIn)
    powerRst |-> cpuRst);
  assert_power_source_R5: assert property (@(posedge clk) disable iff (porIn)
    $rose(powerRst) |-> $past(lviIn));
  assert_status_onehot_R4: assert property (@(posedge clk) disable iff (porIn)
    $countones(status) == 1);
  assert_restart_reload_R6: assert property (@(posedge clk) disable iff (porIn)
    reqAny |=> (pinPullDown && cnt == '0));
  assert_usb_gated_R8: assert property (@(posedge clk) disable iff (porIn)
    (usbReq && !usbEn && !lviIn && !pinReq) |=> $stable(status));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int PIN_CYCLES  = 4096,
  parameter int TAIL_CYCLES = 64
) (
  input  logic         clk,
  input  logic         porIn,
  input  logic         lviIn,
  input  logic         pinIn,
  input  logic         usbReq,
  input  logic         usbEn,
  output logic         pinPullDown,
  output logic         cpuRst,
  output logic         powerRst,
  output logic [3:0]   status
);
  seq_strobe_t strobe;
  logic        reqAny;
  logic        holdDone;
  logic        tailDone;

  rst_seq_ctrl u_ctrl (
    .clk      (clk),
    .porIn    (porIn),
    .reqAny   (reqAny),
    .holdDone (holdDone),
    .tailDone (tailDone),
    .strobe   (strobe)
  );

  rst_seq_dp #(
    .PIN_CYCLES  (PIN_CYCLES),
    .TAIL_CYCLES (TAIL_CYCLES),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk         (clk),
    .porIn       (porIn),
    .lviIn       (lviIn),
    .pinIn       (pinIn),
    .usbReq      (usbReq),
    .usbEn       (usbEn),
    .strobe      (strobe),
    .reqAny      (reqAny),
    .holdDone    (holdDone),
    .tailDone    (tailDone),
    .pinPullDown (pinPullDown),
    .cpuRst      (cpuRst),
    .powerRst    (powerRst),
    .status      (status)
  );
endmodule

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;
  localparam int PIN_N  = 4096;
  localparam int TAIL_N = 64;

  typedef struct {
    logic [3:0] st;
    int         hold;
    int         tail;
    logic       pwr;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic porIn = 1'b1, lviIn = 1'b0, usbReq = 1'b0, usbEn = 1'b1, extLow = 1'b0;
  logic pinPullDown, cpuRst, powerRst;
  logic [3:0] status;
  logic pinLevel;

  int checks = 0, fails = 0, cycles = 0;
  exp_t expQ[$];
  bit   done = 1'b0;

  assign pinLevel = !(pinPullDown || extLow);

  always #10 clk = !clk;

  rst_sequencer #(.PIN_CYCLES(PIN_N), .TAIL_CYCLES(TAIL_N)) u0 (
    .clk(clk), .porIn(porIn), .lviIn(lviIn), .pinIn(pinLevel),
    .usbReq(usbReq), .usbEn(usbEn), .pinPullDown(pinPullDown),
    .cpuRst(cpuRst), .powerRst(powerRst), .status(status)
  );

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_seq(logic [3:0] st, int hold, logic pwr, string tag);
    exp_t e;
    e.st = st; e.hold = hold; e.tail = TAIL_N; e.pwr = pwr; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic wait_done();
    while (expQ.size() != 0) @(negedge clk);
    tick(5);
  endtask

  // Monitor: measures phase lengths and compares against the queue at CPU release.
  int   holdCnt = 0, tailCnt = 0;
  logic prevPd = 1'b1, prevCpu = 1'b1, pwrSeen = 1'b0;
  always @(negedge clk) begin
    if (porIn) begin
      holdCnt = 0; tailCnt = 0; prevPd = 1'b1; prevCpu = 1'b1; pwrSeen = 1'b0;
    end else begin
      if (pinPullDown) begin
        holdCnt = (!prevPd) ? 1 : holdCnt + 1;
        tailCnt = 0;
      end else if (cpuRst) begin
        tailCnt++;
      end
      if (powerRst) pwrSeen = 1'b1;
      if (prevCpu && !cpuRst) begin
        if (expQ.size() == 0) begin
          check("R3 unexpected CPU release", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check({"R2 hold length ", e.tag}, holdCnt, e.hold);
          check({"R3 tail length ", e.tag}, tailCnt, e.tail);
          check({"R4 status ", e.tag}, int'(status), int'(e.st));
          check({"R5 power reset ", e.tag}, int'(pwrSeen), int'(e.pwr));
        end
        holdCnt = 0; tailCnt = 0; pwrSeen = 1'b0;
      end
      prevPd  = pinPullDown;
      prevCpu = cpuRst;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    @(negedge clk);
    check("R1 status at power-on", int'(status), 1);
    check("R1 cpuRst at power-on", int'(cpuRst), 1);
    check("R1 pin pull-down at power-on", int'(pinPullDown), 1);
    check("R1 power reset at power-on", int'(powerRst), 1);
    @(posedge clk); #1;
    expect_seq(4'b0001, PIN_N, 1'b1, "power-on");
    porIn = 1'b0;
    wait_done();

    // Low-voltage single pulse
    expect_seq(4'b0010, PIN_N, 1'b1, "low-voltage");
    lviIn = 1'b1; tick(1); lviIn = 1'b0;
    wait_done();

    // USB bus reset, enabled
    expect_seq(4'b1000, PIN_N, 1'b0, "usb");
    usbReq = 1'b1; tick(1); usbReq = 1'b0;
    wait_done();

    // External pin pulse through the synchronizer (R7)
    expect_seq(4'b0100, PIN_N, 1'b0, "R7 external pin");
    extLow = 1'b1; tick(2); extLow = 1'b0;
    wait_done();

    // R6 held low voltage lengthens the hold phase
    expect_seq(4'b0010, PIN_N + 49, 1'b1, "R6 held low-voltage");
    lviIn = 1'b1; tick(50); lviIn = 1'b0;
    wait_done();

    // R7 external drive while the block pulls the pin low is ignored
    expect_seq(4'b1000, PIN_N, 1'b0, "R7 pin masked during hold");
    usbReq = 1'b1; tick(1); usbReq = 1'b0;
    tick(100); extLow = 1'b1; tick(10); extLow = 1'b0;
    wait_done();

    // R6 restart from the tail phase by a pin request
    expect_seq(4'b0100, PIN_N, 1'b0, "R6 restart in tail");
    usbReq = 1'b1; tick(1); usbReq = 1'b0;
    while (pinPullDown) tick(1);
    tick(10); extLow = 1'b1; tick(2); extLow = 1'b0;
    wait_done();

    // R4 priority: low voltage beats USB in the same cycle
    expect_seq(4'b0010, PIN_N, 1'b1, "R4 priority");
    lviIn = 1'b1; usbReq = 1'b1; tick(1); lviIn = 1'b0; usbReq = 1'b0;
    wait_done();

    // R8 disabled USB request ignored; R9 status retained
    usbEn = 1'b0; usbReq = 1'b1; tick(3); usbReq = 1'b0;
    tick(30);
    @(negedge clk);
    check("R8 cpuRst with usb disabled", int'(cpuRst), 0);
    check("R8 pin with usb disabled", int'(pinPullDown), 0);
    check("R8 status with usb disabled", int'(status), 2);
    tick(100);
    @(negedge clk);
    check("R9 status retained", int'(status), 2);
    check("R9 no pending sequences", expQ.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule